// File: doc/BRIEF.md
# Seven-Bit Address Serial Bus Slave

This block is the target side of a two-wire serial bus that uses a 7-bit address. It oversamples the clock and data lines with the system clock. It finds start, repeated start and stop conditions, and it reads the first byte of each frame as an address followed by a direction bit. When the address equals the configured one, the block acknowledges. It then either delivers written bytes to its local host or fetches bytes from the host and shifts them out.

Both bus lines are driven open-drain: each output requests a pull-down, and the bus level is the wired-AND of all drivers. When the host has not yet taken a received byte, or has not yet supplied the next byte to send, the block holds the clock line low. This makes the master wait, so the host may answer at any pace.

Any start condition puts the block back to address reception, wherever it falls. A stop returns it to idle. Frames for other addresses leave both lines untouched.

Top module: `i2cs7_engine`

## Requirements
- R1: The first byte after a start is taken MSB first as seven address bits then a direction bit (0 write, 1 read). When the address bits equal `own_addr_i`, the block pulls SDA low for the ninth clock of that byte.
- R2: When the address bits differ from `own_addr_i`, the block acknowledges nothing, never pulls SDA or SCL, and delivers no byte until the next start or stop.
- R3: In a write, each following byte is assembled MSB first and shown on `rx_data_o` with `rx_valid_o` high. Both stay unchanged until a cycle with `rx_ready_i` high. The block acknowledges every byte, with no limit on their number.
- R4: In a read, after the address acknowledge the block raises `tx_req_o` and takes `tx_data_i` in the cycle `tx_ready_i` is high. It shifts that byte out MSB first and requests the next byte after each master acknowledge (SDA low on the ninth clock).
- R5: A master not-acknowledge (SDA high on the ninth clock) ends the read. SDA stays released and no further request is raised before the next start.
- R6: SCL is pulled low while a received byte waits for `rx_ready_i` or a byte to send waits for `tx_ready_i`. It is released once the host has answered and the next SDA level is in place.
- R7: A start or repeated start, even in the middle of a byte, drops any partial byte, releases both lines and restarts address reception.
- R8: A stop returns the block to idle. A start followed at once by a stop delivers no byte and raises no request.
- R9: The SDA pull-down changes only while the synchronized SCL is low, `HOLD_CYC` cycles after its falling edge has been seen.
- R10: Start is SDA falling while SCL stays high, and stop is SDA rising while SCL stays high, both judged on the synchronized lines. SDA changes while SCL is low are ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| scl_pull_o | output | 1 | 1 pulls the bus clock line low (stretch) |
| sda_pull_o | output | 1 | 1 pulls the bus data line low |
| own_addr_i | input | 7 | Configured slave address |
| rx_valid_o | output | 1 | A received byte is waiting for the host |
| rx_data_o | output | 8 | Received byte |
| rx_ready_i | input | 1 | Host takes the received byte |
| tx_req_o | output | 1 | Block needs the next byte to send |
| tx_data_i | input | 8 | Byte to send |
| tx_ready_i | input | 1 | Host supplies `tx_data_i` |

## Verification
The bench builds the block with `HOLD_CYC` of 3 and two synchronizer stages. It runs the master at a half period of 24 system cycles, so the data hold and one-cycle setup before the stretch release sit well inside each low phase and can be seen at the bus. The host answers after random latencies of up to 40 cycles, which exercises clock stretching on both receive and transmit. The two-stage synchronizer keeps detection lag short enough that a repeated start placed after four data bits, or a stop right after a start, reaches the block intact.

// File: rtl/i2cs7_pkg.sv
package i2cs7_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_RXHOLD,
        ST_RACK,
        ST_TXLOAD,
        ST_TX,
        ST_TXACK,
        ST_PARK
    } eng_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } line_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] first_byte,
                                      input logic [ADDR_W-1:0] mine);
        return first_byte[BYTE_W-1:1] == mine;
    endfunction

endpackage

// File: rtl/i2cs7_sync.sv
module i2cs7_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2cs7_events.sv
module i2cs7_events
    import i2cs7_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output line_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.start    = scl_q & scl_s & sda_q & ~sda_s;
        ev.stop     = scl_q & scl_s & ~sda_q & sda_s;
        ev.scl_rise = ~scl_q & scl_s;
        ev.scl_fall = scl_q & ~scl_s;
    end
endmodule

// File: rtl/i2cs7_drive.sv
module i2cs7_drive #(
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic sched,
    input  logic sched_val,
    output logic sda_pull,
    output logic pend,
    output logic done
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] hcnt;
    logic          val;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hcnt     <= '0;
            val      <= 1'b0;
            pend     <= 1'b0;
            sda_pull <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (sched) begin
                pend <= 1'b1;
                val  <= sched_val;
                hcnt <= HW'(HOLD_CYC);
            end else if (pend) begin
                if (hcnt == '0) begin
                    sda_pull <= val;
                    pend     <= 1'b0;
                    done     <= 1'b1;
                end else begin
                    hcnt <= hcnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/i2cs7_engine.sv
module i2cs7_engine
    import i2cs7_pkg::*;
#(
    parameter int HOLD_CYC    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pull_o,
    output logic              sda_pull_o,
    input  logic [ADDR_W-1:0] own_addr_i,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_data_o,
    input  logic              rx_ready_i,
    output logic              tx_req_o,
    input  logic [BYTE_W-1:0] tx_data_i,
    input  logic              tx_ready_i
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, syn_lines;
    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        i2cs7_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw_lines[g]),
            .dout(syn_lines[g])
        );
    end

    line_ev_t ev;
    i2cs7_events u_ev (
        .clk  (clk),
        .rst  (rst),
        .scl_s(syn_lines[1]),
        .sda_s(syn_lines[0]),
        .ev   (ev)
    );

    eng_state_t        st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw, mack;
    logic              sched, sched_val;
    logic              drv_pend, drv_done;

    i2cs7_drive #(.HOLD_CYC(HOLD_CYC)) u_drv (
        .clk      (clk),
        .rst      (rst),
        .clr      (ev.start | ev.stop),
        .sched    (sched),
        .sched_val(sched_val),
        .sda_pull (sda_pull_o),
        .pend     (drv_pend),
        .done     (drv_done)
    );

    assign tx_req_o = (st == ST_TXLOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            rw         <= 1'b0;
            mack       <= 1'b0;
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
            scl_pull_o <= 1'b0;
            sched      <= 1'b0;
            sched_val  <= 1'b0;
        end else begin
            sched <= 1'b0;
            if (drv_done) scl_pull_o <= 1'b0;
            if (ev.start) begin
                st         <= ST_ADDR;
                cnt        <= '0;
                rx_valid_o <= 1'b0;
                scl_pull_o <= 1'b0;
            end else if (ev.stop) begin
                st         <= ST_IDLE;
                cnt        <= '0;
                rx_valid_o <= 1'b0;
                scl_pull_o <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_RX: begin
                        if (ev.scl_rise && cnt < CNT_W'(BYTE_W)) begin
                            shreg <= {shreg[BYTE_W-2:0], ev.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.scl_fall && cnt == CNT_W'(BYTE_W)) begin
                            if (st == ST_RX) begin
                                rx_valid_o <= 1'b1;
                                rx_data_o  <= shreg;
                                scl_pull_o <= 1'b1;
                                st         <= ST_RXHOLD;
                            end else if (addr_hit(shreg, own_addr_i)) begin
                                rw        <= shreg[0];
                                sched     <= 1'b1;
                                sched_val <= 1'b1;
                                st        <= ST_AACK;
                            end else begin
                                st <= ST_PARK;
                            end
                        end
                    end
                    ST_AACK: if (ev.scl_fall) begin
                        if (rw) begin
                            scl_pull_o <= 1'b1;
                            st         <= ST_TXLOAD;
                        end else begin
                            cnt       <= '0;
                            sched     <= 1'b1;
                            sched_val <= 1'b0;
                            st        <= ST_RX;
                        end
                    end
                    ST_RXHOLD: if (rx_ready_i) begin
                        rx_valid_o <= 1'b0;
                        sched      <= 1'b1;
                        sched_val  <= 1'b1;
                        st         <= ST_RACK;
                    end
                    ST_RACK: if (ev.scl_fall) begin
                        cnt       <= '0;
                        sched     <= 1'b1;
                        sched_val <= 1'b0;
                        st        <= ST_RX;
                    end
                    ST_TXLOAD: if (tx_ready_i) begin
                        shreg     <= tx_data_i;
                        cnt       <= '0;
                        sched     <= 1'b1;
                        sched_val <= ~tx_data_i[BYTE_W-1];
                        st        <= ST_TX;
                    end
                    ST_TX: if (ev.scl_fall) begin
                        sched <= 1'b1;
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            sched_val <= 1'b0;
                            st        <= ST_TXACK;
                        end else begin
                            shreg     <= {shreg[BYTE_W-2:0], 1'b0};
                            sched_val <= ~shreg[BYTE_W-2];
                            cnt       <= cnt + 1'b1;
                        end
                    end
                    ST_TXACK: begin
                        if (ev.scl_rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mack) begin
                                scl_pull_o <= 1'b1;
                                st         <= ST_TXLOAD;
                            end else begin
                                st <= ST_PARK;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (sda_pull_o != $past(sda_pull_o)) |-> !$past(ev.scl)); // R9

    AST_STRETCH_WHEN_WAITING: assert property (@(posedge clk) disable iff (rst)
        scl_pull_o |-> (st == ST_RXHOLD || st == ST_TXLOAD || sched || drv_pend || drv_done)); // R6

    AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_o && !rx_ready_i && !ev.start && !ev.stop) |=> (rx_valid_o && $stable(rx_data_o))); // R3

    AST_START_REARM: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (st == ST_ADDR && cnt == '0 && !scl_pull_o && !sda_pull_o)); // R7

    AST_REQ_VALID_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(tx_req_o && rx_valid_o)); // R4

    AST_PARK_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PARK && $past(st) == ST_PARK) |-> (!scl_pull_o && !rx_valid_o && !tx_req_o)); // R2

endmodule

// File: tb/sim_i2cs7_engine.sv
module sim_i2cs7_engine;
    localparam int Q = 24;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_pull_o, sda_pull_o;
    logic rx_valid_o, tx_req_o;
    logic [7:0] rx_data_o;
    logic rx_ready_i = 1'b0, tx_ready_i = 1'b0;
    logic [7:0] tx_data_i = 8'h00;
    logic [6:0] own_addr = OWN;

    wire scl_bus = m_scl & ~scl_pull_o;
    wire sda_bus = m_sda & ~sda_pull_o;

    i2cs7_engine #(.HOLD_CYC(3), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o), .own_addr_i(own_addr),
        .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .rx_ready_i(rx_ready_i),
        .tx_req_o(tx_req_o), .tx_data_i(tx_data_i), .tx_ready_i(tx_ready_i)
    );

    int n_chk = 0, n_fail = 0;
    int rx_n = 0, tx_n = 0, rx_lat = 0, tx_lat = 0;
    int stretch_cnt = 0, pull_cnt = 0, sda_viol = 0, req_cnt = 0;
    logic [7:0] rx_got [0:63];
    logic [7:0] tx_src [0:63];
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // host receive side
    initial forever begin
        @(negedge clk);
        if (rx_valid_o) begin
            repeat (rx_lat) @(negedge clk);
            rx_got[rx_n % 64] = rx_data_o;
            rx_n++;
            rx_ready_i = 1'b1;
            @(negedge clk);
            rx_ready_i = 1'b0;
        end
    end

    // host transmit side
    initial forever begin
        @(negedge clk);
        if (tx_req_o) begin
            repeat (tx_lat) @(negedge clk);
            tx_data_i = tx_src[tx_n % 64];
            tx_n++;
            tx_ready_i = 1'b1;
            @(negedge clk);
            tx_ready_i = 1'b0;
        end
    end

    // bus monitors
    initial begin
        logic prev_sda = 1'b0, prev_req = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (scl_pull_o) stretch_cnt++;
                if (scl_pull_o || sda_pull_o) pull_cnt++;
                if (sda_pull_o != prev_sda && scl_bus) sda_viol++;
                if (tx_req_o && !prev_req) req_cnt++;
            end
            prev_sda = sda_pull_o;
            prev_req = tx_req_o;
        end
    end

    task automatic m_bit(input logic b, output logic r);
        m_sda = b;
        wcyc(Q);
        m_scl = 1'b1;
        while (!scl_bus) @(negedge clk);
        wcyc(Q);
        r = sda_bus;
        m_scl = 1'b0;
        wcyc(2);
    endtask

    task automatic m_start();
        m_sda = 1'b1;
        wcyc(Q);
        m_scl = 1'b1;
        while (!scl_bus) @(negedge clk);
        wcyc(Q);
        m_sda = 1'b0;
        wcyc(Q);
        m_scl = 1'b0;
        wcyc(Q);
    endtask

    task automatic m_stop();
        m_sda = 1'b0;
        wcyc(Q);
        m_scl = 1'b1;
        while (!scl_bus) @(negedge clk);
        wcyc(Q);
        m_sda = 1'b1;
        wcyc(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(d[i], r);
        m_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic m_rbyte(output logic [7:0] d, input logic give_ack);
        logic r;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            m_bit(1'b1, r);
            d = {d[6:0], r};
        end
        m_bit(~give_ack, r);
    endtask

    task automatic do_write(input int n, input int lat);
        int base;
        logic ack;
        logic [7:0] exp_b [0:15];
        base = rx_n;
        rx_lat = lat;
        m_start();
        m_wbyte({OWN, 1'b0}, ack);
        chk(ack, "R1", "address ack on write", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            exp_b[i] = 8'($urandom_range(255, 0));
            m_wbyte(exp_b[i], ack);
            chk(ack, "R3", "data byte ack", int'(ack), 1);
        end
        m_stop();
        wcyc(4);
        chk(rx_n == base + n, "R3", "bytes delivered", rx_n - base, n);
        for (int i = 0; i < n; i++)
            chk(rx_got[(base + i) % 64] == exp_b[i], "R3", "byte value",
                int'(rx_got[(base + i) % 64]), int'(exp_b[i]));
        chk(!sda_pull_o && !scl_pull_o, "R8", "lines free after stop",
            int'(sda_pull_o | scl_pull_o), 0);
    endtask

    task automatic do_read(input int n, input int lat);
        int base;
        logic ack;
        logic [7:0] d;
        base = tx_n;
        tx_lat = lat;
        for (int i = 0; i < n; i++) tx_src[(base + i) % 64] = 8'($urandom_range(255, 0));
        m_start();
        m_wbyte({OWN, 1'b1}, ack);
        chk(ack, "R1", "address ack on read", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            m_rbyte(d, i < n - 1);
            chk(d == tx_src[(base + i) % 64], "R4", "byte sent",
                int'(d), int'(tx_src[(base + i) % 64]));
        end
        wcyc(Q);
        chk(!sda_pull_o, "R5", "SDA released after nack", int'(sda_pull_o), 0);
        chk(!tx_req_o, "R5", "no request after nack", int'(tx_req_o), 0);
        chk(tx_n == base + n, "R5", "bytes fetched", tx_n - base, n);
        m_stop();
        wcyc(4);
    endtask

    initial begin
        logic ack;
        logic r;
        logic [7:0] d;
        int base_rx, base_tx, base_req;
        void'($urandom(32'd2718));
        wcyc(5);
        rst = 1'b0;
        wcyc(2);
        // reset state
        chk(!sda_pull_o, "R8", "reset sda_pull", int'(sda_pull_o), 0);
        chk(!scl_pull_o, "R8", "reset scl_pull", int'(scl_pull_o), 0);
        chk(!rx_valid_o, "R8", "reset rx_valid", int'(rx_valid_o), 0);
        chk(!tx_req_o, "R8", "reset tx_req", int'(tx_req_o), 0);

        // void frame
        base_rx = rx_n; base_req = req_cnt;
        m_start();
        m_stop();
        wcyc(8);
        chk(rx_n == base_rx, "R8", "void frame delivers nothing", rx_n - base_rx, 0);
        chk(req_cnt == base_req, "R8", "void frame raises no request", req_cnt - base_req, 0);
        chk(!sda_pull_o && !scl_pull_o, "R8", "void frame lines free", int'(sda_pull_o | scl_pull_o), 0);

        // write with a slow host: stretch
        stretch_cnt = 0;
        do_write(3, 40);
        chk(stretch_cnt >= 3 * 40, "R6", "stretch on slow receive", stretch_cnt, 3 * 40);

        // read with a slow host: stretch
        stretch_cnt = 0;
        do_read(3, 30);
        chk(stretch_cnt >= 3 * 30, "R6", "stretch on slow transmit", stretch_cnt, 3 * 30);

        // foreign address stays silent
        base_rx = rx_n; pull_cnt = 0;
        m_start();
        m_wbyte({OWN ^ 7'h21, 1'b0}, ack);
        chk(!ack, "R2", "foreign address not acked", int'(ack), 0);
        m_wbyte(8'h00, ack);
        chk(!ack, "R2", "foreign data not acked", int'(ack), 0);
        m_stop();
        wcyc(4);
        chk(pull_cnt == 0, "R2", "no pull on foreign frame", pull_cnt, 0);
        chk(rx_n == base_rx, "R2", "no byte on foreign frame", rx_n - base_rx, 0);

        // repeated start in the middle of a byte
        base_rx = rx_n;
        rx_lat = 0;
        m_start();
        m_wbyte({OWN, 1'b0}, ack);
        chk(ack, "R1", "address ack before restart", int'(ack), 1);
        for (int i = 0; i < 4; i++) m_bit(1'(i & 1), r);
        base_tx = tx_n;
        tx_src[base_tx % 64] = 8'h96;
        tx_lat = 5;
        m_start();
        m_wbyte({OWN, 1'b1}, ack);
        chk(ack, "R7", "address ack after mid-byte restart", int'(ack), 1);
        m_rbyte(d, 1'b0);
        chk(d == 8'h96, "R7", "read after restart", int'(d), 'h96);
        m_stop();
        wcyc(4);
        chk(rx_n == base_rx, "R7", "partial byte dropped", rx_n - base_rx, 0);

        // stop ends the frame: later bits without start are ignored
        base_rx = rx_n; pull_cnt = 0;
        m_start();
        m_wbyte({OWN, 1'b0}, ack);
        m_stop();
        pull_cnt = 0;
        m_scl = 1'b0;
        wcyc(Q);
        m_wbyte(8'h3C, ack);
        chk(!ack, "R10", "no ack without start", int'(ack), 0);
        m_scl = 1'b1; m_sda = 1'b1;
        wcyc(Q);
        chk(pull_cnt == 0, "R10", "bits after stop ignored", pull_cnt, 0);
        chk(rx_n == base_rx, "R10", "no byte after stop", rx_n - base_rx, 0);

        // mixed random traffic
        for (int it = 0; it < 6; it++) begin
            if ($urandom_range(1, 0) == 1)
                do_write(int'($urandom_range(5, 1)), int'($urandom_range(20, 0)));
            else
                do_read(int'($urandom_range(5, 1)), int'($urandom_range(20, 0)));
        end

        chk(sda_viol == 0, "R9", "SDA changed while SCL high", sda_viol, 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(negedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule